// File: doc/BRIEF.md
# PLL divider parameter search engine

This block chooses a configuration for a clock synthesiser. It takes a target output frequency and up to three candidate reference clocks. It then searches the legal settings of a pre-divider M, a feedback multiplier N, a power-of-two post-divider exponent E and an integer output divider DIV. It keeps the setting whose output lies closest to the target. An optional fixed divide-by-seven stage sits after the post-divider. The stage is bypassed when the result feeds a pixel clock directly rather than a seven-bit serialiser. The winning setting is packed into two control words ready to be written to a synthesiser.

All frequencies are 32-bit integers in Hz, and every intermediate quotient uses truncating integer division. Software or a sequencer drives the target, the reference frequencies, their valid flags and the dot-clock-only flag, then pulses `start`. The engine runs its nested search on one shared iterative divider, holding `busy` high. When it finishes it pulses `done` and holds the result until the next start.

The controller has fourteen named states:

- `S_IDLE` waits for start.
- `S_REF` qualifies the current reference, or steps to the next one.
- `S_MLO` and `S_MHI` compute the M bounds; `S_MCHK` tests the M loop.
- `S_PFD` computes the comparison frequency.
- `S_NLO` and `S_NHI` compute the N bounds; `S_NCHK` tests the N loop.
- `S_ESET` forms the VCO frequency and the first E.
- `S_SEVEN` applies the optional divide by seven.
- `S_ROUND` picks DIV.
- `S_QUOT` scores the candidate and advances E or N.
- `S_FINISH` raises done.

The transitions are:

- IDLE→REF on start.
- REF→MLO for a usable reference.
- REF→REF for a skipped one.
- REF→FINISH after the third reference.
- MLO→MHI→MCHK.
- MCHK→PFD while M is in range, otherwise back to REF.
- PFD→NLO→NHI→NCHK.
- NCHK→ESET while N is in range, otherwise back to MCHK.
- ESET→SEVEN→ROUND→QUOT.
- QUOT→SEVEN for the next E, QUOT→NCHK after the last E, and QUOT→FINISH on an exact hit.
- FINISH→IDLE.

Top module: `pllcfg_search`

## Requirements
- R1: After reset, `busy` and `done` are low, `no_solution` is high, `err_hz` is all ones and both control words are zero.
- R2: A reference is used only if its valid flag is set and its frequency lies in 12 000 000..192 000 000 Hz inclusive. If no setting is found, `done` comes with `no_solution` high, both words zero and `err_hz` all ones.
- R3: M takes every value from max(1, ceil(Fin/24 MHz)) to min(8, floor(Fin/12 MHz)) inclusive. M−1 appears in `pll_word[13:11]`.
- R4: With Fpfd = floor(Fin/M), N takes every value from max(60, ceil(900 MHz/Fpfd)) up to, but excluding, min(120, floor(1800 MHz/Fpfd)). N−1 appears in `pll_word[10:4]`.
- R5: With Fvco = Fpfd·N, E runs to 2 inclusive. It starts at 1 when Fvco > 1 039 500 000 and at 0 otherwise. Fout = floor(Fvco/2^E). When E > 0, `pll_word[14]` = E−1 and bits 15 and 16 are set; otherwise all three are zero.
- R6: Fout is further divided (truncating) by 7 unless `dot_only` was high at start. `pll_word[17]` reports `dot_only` for a found setting.
- R7: DIV = max(1, floor((Fout + floor(target/2)) / target)). The candidate error is |floor(Fout/DIV) − target|, and `err_hz` reports the error of the kept setting.
- R8: Candidates are tried with M ascending, then N ascending, then E ascending. A candidate replaces the kept one only if its error is strictly smaller, so on a tie the earlier one is kept.
- R9: The search stops as soon as a candidate with zero error is found.
- R10: References are tried in the order dot-clock input 0, dot-clock input 1, crystal. `src_sel` reports the winner as 0, 1 or 2, and the kept result carries across all three.
- R11: For a found setting, `pll_word` bit 0 (synthesiser on) and bit 3 (clock output enable) are 1, `pll_word[2:1]` = `src_sel`, and bits 31:18 are zero.
- R12: When DIV > 1, `div_word` has bit 17 (divider select) and bit 16 (reset release) set and DIV−1 in bits 15:0. Otherwise `div_word` is zero.
- R13: `start` while idle begins a search with `busy` high on the next cycle. `start` during a search is ignored. `done` is a one-cycle pulse with `busy` low, and the results stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| target_hz | input | 32 | Wanted output frequency in Hz, captured at start |
| ref0_hz | input | 32 | Dot-clock input 0 frequency in Hz |
| ref1_hz | input | 32 | Dot-clock input 1 frequency in Hz |
| ref2_hz | input | 32 | Crystal frequency in Hz |
| ref_valid | input | 3 | Presence flag per reference, bit i for reference i |
| dot_only | input | 1 | Bypass the fixed divide-by-seven stage, captured at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| no_solution | output | 1 | No legal setting was found |
| src_sel | output | 2 | Winning reference index |
| pll_word | output | 32 | Packed synthesiser control word |
| div_word | output | 32 | Packed output divider control word |
| err_hz | output | 32 | Absolute error of the kept setting in Hz |

## Verification
The checks assume three things about the inputs. The target is at least 32 768 Hz and no more than 2 000 000 000 Hz, so DIV−1 fits its 16-bit field and the rounding sum stays within 32 bits. The reference frequencies and valid flags stay constant while `busy` is high. `start` is taken only from idle. The bench sets every input before pulsing start and leaves the references alone until `done`. Its one mid-search start pulse tests that such a pulse is ignored, and that test checks the result against the originally captured target. The field-range assertions rely on the search bounds above, which hold for any reference inside the accepted window.

// File: rtl/pllcfg_pkg.sv
`timescale 1ns/1ps
package pllcfg_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_REF, S_MLO, S_MHI, S_MCHK, S_PFD, S_NLO, S_NHI,
        S_NCHK, S_ESET, S_SEVEN, S_ROUND, S_QUOT, S_FINISH
    } srch_state_t;

    localparam int CFG_W     = 32;
    localparam int REF_CNT   = 3;
    // synthesiser word layout
    localparam int PW_ON     = 0;
    localparam int PW_SRC    = 1;
    localparam int PW_CKOUT  = 3;
    localparam int PW_N      = 4;
    localparam int PW_N_W    = 7;
    localparam int PW_M      = 11;
    localparam int PW_M_W    = 3;
    localparam int PW_E      = 14;
    localparam int PW_STP    = 15;
    localparam int PW_OSEL   = 16;
    localparam int PW_DOT    = 17;
    // divider word layout
    localparam int DV_VAL    = 0;
    localparam int DV_VAL_W  = 16;
    localparam int DV_RLS    = 16;
    localparam int DV_SEL    = 17;
endpackage

// File: rtl/pllcfg_divu.sv
`timescale 1ns/1ps
module pllcfg_divu #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem, dsr;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    rsh, trial;

    always_comb begin
        rsh   = {rem, quo[W-1]};
        trial = rsh - {1'b0, dsr};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem  <= '0;
            dsr  <= '0;
            quo  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem <= '0;
                quo <= num;
                dsr <= den;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                if (!trial[W]) begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= rsh[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pllcfg_pack.sv
`timescale 1ns/1ps
module pllcfg_pack
    import pllcfg_pkg::*;
#(
    parameter int FW = 32,
    parameter int MW = 4,
    parameter int NW = 8,
    parameter int EW = 2
) (
    input  logic             found,
    input  logic [1:0]       src,
    input  logic [MW-1:0]    m,
    input  logic [NW-1:0]    n,
    input  logic [EW-1:0]    e,
    input  logic [FW-1:0]    divv,
    input  logic             dot,
    output logic [CFG_W-1:0] pll_word,
    output logic [CFG_W-1:0] div_word
);
    always_comb begin
        pll_word = '0;
        div_word = '0;
        if (found) begin
            pll_word[PW_ON]           = 1'b1;
            pll_word[PW_SRC +: 2]     = src;
            pll_word[PW_CKOUT]        = 1'b1;
            pll_word[PW_N +: PW_N_W]  = PW_N_W'(n - NW'(1));
            pll_word[PW_M +: PW_M_W]  = PW_M_W'(m - MW'(1));
            pll_word[PW_DOT]          = dot;
            if (e != '0) begin
                pll_word[PW_E]    = 1'(e - EW'(1));
                pll_word[PW_STP]  = 1'b1;
                pll_word[PW_OSEL] = 1'b1;
            end
            if (divv > FW'(1)) begin
                div_word[DV_SEL]              = 1'b1;
                div_word[DV_RLS]              = 1'b1;
                div_word[DV_VAL +: DV_VAL_W]  = DV_VAL_W'(divv - FW'(1));
            end
        end
    end
endmodule

// File: rtl/pllcfg_search.sv
`timescale 1ns/1ps
module pllcfg_search
    import pllcfg_pkg::*;
#(
    parameter int             FW        = 32,
    parameter int             M_MAX     = 8,
    parameter int             N_MIN     = 60,
    parameter int             N_MAX     = 120,
    parameter int             E_MAX     = 2,
    parameter int             FIXED_DIV = 7,
    parameter logic [FW-1:0]  REF_MIN   = 12_000_000,
    parameter logic [FW-1:0]  REF_MAX   = 192_000_000,
    parameter logic [FW-1:0]  PFD_MIN   = 12_000_000,
    parameter logic [FW-1:0]  PFD_MAX   = 24_000_000,
    parameter logic [FW-1:0]  VCO_MIN   = 900_000_000,
    parameter logic [FW-1:0]  VCO_MAX   = 1_800_000_000,
    parameter logic [FW-1:0]  FOUT_MAX  = 1_039_500_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FW-1:0]    target_hz,
    input  logic [FW-1:0]    ref0_hz,
    input  logic [FW-1:0]    ref1_hz,
    input  logic [FW-1:0]    ref2_hz,
    input  logic [2:0]       ref_valid,
    input  logic             dot_only,
    output logic             busy,
    output logic             done,
    output logic             no_solution,
    output logic [1:0]       src_sel,
    output logic [CFG_W-1:0] pll_word,
    output logic [CFG_W-1:0] div_word,
    output logic [FW-1:0]    err_hz
);
    localparam int MW = $clog2(M_MAX + 2);
    localparam int NW = $clog2(N_MAX + 1) + 1;
    localparam int EW = $clog2(E_MAX + 1);
    localparam int PW = FW + NW;

    srch_state_t st, nxt;

    logic [1:0]    ref_idx;
    logic [FW-1:0] fin, tgt, pfd, fvco, fout, divv;
    logic          dot_r, issued;
    logic [MW-1:0] m, m_hi;
    logic [NW-1:0] n, n_hi;
    logic [EW-1:0] e;

    logic [1:0]    b_src;
    logic [MW-1:0] b_m;
    logic [NW-1:0] b_n;
    logic [EW-1:0] b_e;
    logic [FW-1:0] b_div, b_err;

    logic          dv_go, dv_done, op_on, step, ref_ok, cur_vld;
    logic [FW-1:0] dv_num, dv_den, dv_q, cur_ref, cand_err;
    logic [PW-1:0] prod;

    pllcfg_divu #(.W(FW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(dv_go), .num(dv_num), .den(dv_den),
        .done(dv_done), .quo(dv_q)
    );

    // reference selection and candidate scoring
    always_comb begin
        unique case (ref_idx)
            2'd0:    begin cur_ref = ref0_hz; cur_vld = ref_valid[0]; end
            2'd1:    begin cur_ref = ref1_hz; cur_vld = ref_valid[1]; end
            2'd2:    begin cur_ref = ref2_hz; cur_vld = ref_valid[2]; end
            default: begin cur_ref = '0;      cur_vld = 1'b0;         end
        endcase
        ref_ok   = cur_vld && (cur_ref >= REF_MIN) && (cur_ref <= REF_MAX);
        cand_err = (dv_q >= tgt) ? dv_q - tgt : tgt - dv_q;
        prod     = PW'(pfd) * PW'(n);
        step     = issued && dv_done;
    end

    // divider operand selection per state
    always_comb begin
        op_on  = 1'b1;
        dv_num = '0;
        dv_den = '0;
        unique case (st)
            S_MLO:   begin dv_num = fin + PFD_MAX - FW'(1); dv_den = PFD_MAX;      end
            S_MHI:   begin dv_num = fin;                    dv_den = PFD_MIN;      end
            S_PFD:   begin dv_num = fin;                    dv_den = FW'(m);       end
            S_NLO:   begin dv_num = VCO_MIN + pfd - FW'(1); dv_den = pfd;          end
            S_NHI:   begin dv_num = VCO_MAX;                dv_den = pfd;          end
            S_SEVEN: begin dv_num = fvco >> e; dv_den = FW'(FIXED_DIV); op_on = !dot_r; end
            S_ROUND: begin dv_num = fout + (tgt >> 1);      dv_den = tgt;          end
            S_QUOT:  begin dv_num = fout;                   dv_den = divv;         end
            default: op_on = 1'b0;
        endcase
        dv_go = op_on && !issued;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:   if (start) nxt = S_REF;
            S_REF:    if (ref_idx == 2'(REF_CNT)) nxt = S_FINISH;
                      else if (ref_ok)             nxt = S_MLO;
            S_MLO:    if (step) nxt = S_MHI;
            S_MHI:    if (step) nxt = S_MCHK;
            S_MCHK:   nxt = (m <= m_hi) ? S_PFD : S_REF;
            S_PFD:    if (step) nxt = S_NLO;
            S_NLO:    if (step) nxt = S_NHI;
            S_NHI:    if (step) nxt = S_NCHK;
            S_NCHK:   nxt = (n < n_hi) ? S_ESET : S_MCHK;
            S_ESET:   nxt = S_SEVEN;
            S_SEVEN:  if (dot_r || step) nxt = S_ROUND;
            S_ROUND:  if (step) nxt = S_QUOT;
            S_QUOT:   if (step) begin
                          if (cand_err == '0)          nxt = S_FINISH;
                          else if (e < EW'(E_MAX))     nxt = S_SEVEN;
                          else                         nxt = S_NCHK;
                      end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // datapath and kept result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_idx <= '0; fin <= '0; tgt <= '0; dot_r <= 1'b0; issued <= 1'b0;
            m <= '0; m_hi <= '0; pfd <= '0; n <= '0; n_hi <= '0;
            fvco <= '0; e <= '0; fout <= '0; divv <= '0;
            b_src <= '0; b_m <= '0; b_n <= '0; b_e <= '0; b_div <= '0; b_err <= '1;
        end else begin
            if (dv_go)     issued <= 1'b1;
            else if (step) issued <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    ref_idx <= '0; tgt <= target_hz; dot_r <= dot_only;
                    b_src <= '0; b_m <= '0; b_n <= '0; b_e <= '0; b_div <= '0; b_err <= '1;
                end
                S_REF: if (ref_idx != 2'(REF_CNT)) begin
                    if (ref_ok) fin <= cur_ref;
                    else        ref_idx <= ref_idx + 2'd1;
                end
                S_MLO:  if (step) m    <= (dv_q == '0) ? MW'(1) : MW'(dv_q);
                S_MHI:  if (step) m_hi <= (dv_q > FW'(M_MAX)) ? MW'(M_MAX) : MW'(dv_q);
                S_MCHK: if (!(m <= m_hi)) ref_idx <= ref_idx + 2'd1;
                S_PFD:  if (step) pfd  <= dv_q;
                S_NLO:  if (step) n    <= (dv_q < FW'(N_MIN)) ? NW'(N_MIN) : NW'(dv_q);
                S_NHI:  if (step) n_hi <= (dv_q > FW'(N_MAX)) ? NW'(N_MAX) : NW'(dv_q);
                S_NCHK: if (!(n < n_hi)) m <= m + MW'(1);
                S_ESET: begin
                    fvco <= prod[FW-1:0];
                    e    <= (prod > {{NW{1'b0}}, FOUT_MAX}) ? EW'(1) : EW'(0);
                end
                S_SEVEN: if (dot_r)     fout <= fvco >> e;
                         else if (step) fout <= dv_q;
                S_ROUND: if (step) divv <= (dv_q == '0) ? FW'(1) : dv_q;
                S_QUOT: if (step) begin
                    if (cand_err < b_err) begin
                        b_err <= cand_err; b_src <= ref_idx; b_m <= m;
                        b_n <= n; b_e <= e; b_div <= divv;
                    end
                    if (cand_err != '0) begin
                        if (e < EW'(E_MAX)) e <= e + EW'(1);
                        else                n <= n + NW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    pllcfg_pack #(.FW(FW), .MW(MW), .NW(NW), .EW(EW)) u_pack (
        .found(b_err != '1), .src(b_src), .m(b_m), .n(b_n), .e(b_e),
        .divv(b_div), .dot(dot_r), .pll_word(pll_word), .div_word(div_word)
    );

    assign busy        = (st != S_IDLE) && (st != S_FINISH);
    assign done        = (st == S_FINISH);
    assign no_solution = (b_err == '1);
    assign src_sel     = b_src;
    assign err_hz      = b_err;
endmodule

// File: rtl/pllcfg_search_chk.sv
`timescale 1ns/1ps
module pllcfg_search_chk
    import pllcfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             no_solution,
    input logic [1:0]       src_sel,
    input logic [CFG_W-1:0] pll_word,
    input logic [CFG_W-1:0] div_word,
    input logic [31:0]      err_hz
);
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_launch_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    p_result_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(pll_word) && $stable(div_word) &&
                               $stable(err_hz) && $stable(no_solution)));

    // R4: N field reflects N in 60..119
    p_nfield_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_solution) |->
            (pll_word[PW_N +: PW_N_W] >= 7'd59 && pll_word[PW_N +: PW_N_W] <= 7'd118));

    // R10: only three sources exist
    p_src_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_solution) |-> (src_sel != 2'd3));
endmodule

bind pllcfg_search pllcfg_search_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .no_solution(no_solution), .src_sel(src_sel), .pll_word(pll_word),
    .div_word(div_word), .err_hz(err_hz)
);

// File: tb/pllcfg_search_bench.sv
`timescale 1ns/1ps
module pllcfg_search_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] target_hz = '0, ref0_hz = '0, ref1_hz = '0, ref2_hz = '0;
    logic [2:0]  ref_valid = '0;
    logic        dot_only = 1'b0;
    logic        busy, done, no_solution;
    logic [1:0]  src_sel;
    logic [31:0] pll_word, div_word, err_hz;

    int n_chk = 0;
    int n_bad = 0;
    localparam int WDOG = 60000;

    always #10 clk = ~clk;

    pllcfg_search u_pllcfg_search (
        .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
        .ref0_hz(ref0_hz), .ref1_hz(ref1_hz), .ref2_hz(ref2_hz),
        .ref_valid(ref_valid), .dot_only(dot_only), .busy(busy), .done(done),
        .no_solution(no_solution), .src_sel(src_sel), .pll_word(pll_word),
        .div_word(div_word), .err_hz(err_hz)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // arithmetic model of the search
    task automatic model(input longint r0, r1, r2, input bit [2:0] vld,
                         input longint tgt, input bit dot,
                         output bit nsol, output longint src, mm, nn, ee, dd, err);
        longint refs[3];
        bit exact;
        refs[0] = r0; refs[1] = r1; refs[2] = r2;
        err = 64'hFFFF_FFFF; exact = 0; src = 0; mm = 0; nn = 0; ee = 0; dd = 0;
        for (int s = 0; s < 3; s++) begin
            longint fin, mlo, mhi;
            fin = refs[s];
            if (exact || !vld[s] || fin < 12_000_000 || fin > 192_000_000) continue;
            mlo = (fin + 24_000_000 - 1) / 24_000_000; if (mlo < 1) mlo = 1;
            mhi = fin / 12_000_000; if (mhi > 8) mhi = 8;
            for (longint m = mlo; m <= mhi && !exact; m++) begin
                longint pfd, nlo, nhi;
                pfd = fin / m;
                nlo = (900_000_000 + pfd - 1) / pfd; if (nlo < 60) nlo = 60;
                nhi = 1_800_000_000 / pfd; if (nhi > 120) nhi = 120;
                for (longint n = nlo; n < nhi && !exact; n++) begin
                    longint fvco, e0;
                    fvco = pfd * n;
                    e0 = (fvco > 1_039_500_000) ? 1 : 0;
                    for (longint e = e0; e <= 2 && !exact; e++) begin
                        longint fo, d, v, df;
                        fo = fvco >> e;
                        if (!dot) fo = fo / 7;
                        d = (fo + tgt / 2) / tgt; if (d < 1) d = 1;
                        v = fo / d;
                        df = (v >= tgt) ? v - tgt : tgt - v;
                        if (df < err) begin
                            err = df; src = s; mm = m; nn = n; ee = e; dd = d;
                            if (df == 0) exact = 1;
                        end
                    end
                end
            end
        end
        nsol = (err == 64'hFFFF_FFFF);
    endtask

    task automatic run(input longint r0, r1, r2, input bit [2:0] vld,
                       input longint tgt, input bit dot, input bit poke,
                       output int lat);
        bit nsol; longint src, mm, nn, ee, dd, err, xp, xd;
        logic [31:0] keep_pll;
        model(r0, r1, r2, vld, tgt, dot, nsol, src, mm, nn, ee, dd, err);
        @(negedge clk);
        ref0_hz = 32'(r0); ref1_hz = 32'(r1); ref2_hz = 32'(r2);
        ref_valid = vld; target_hz = 32'(tgt); dot_only = dot; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R13 busy after start", busy, 1);
        lat = 1;
        while (!done && lat < WDOG) begin
            if (poke && lat == 40) begin
                target_hz = 32'(tgt + 1234); dot_only = !dot; start = 1'b1;
            end else begin
                start = 1'b0; target_hz = 32'(tgt); dot_only = dot;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        if (!done) begin
            chk("R13 watchdog expired", 0, 1);
            return;
        end
        chk("R13 busy low at done", busy, 0);
        chk("R2 no_solution", no_solution, nsol);
        xp = 0; xd = 0;
        if (!nsol) begin
            xp = 1 | (src << 1) | (1 << 3) | ((nn - 1) << 4) | ((mm - 1) << 11) | (longint'(dot) << 17);
            if (ee > 0) xp = xp | ((ee - 1) << 14) | (1 << 15) | (1 << 16);
            if (dd > 1) xd = (1 << 17) | (1 << 16) | (dd - 1);
            chk("R10 source index", src_sel, src);
        end
        chk("R3 M field", pll_word[13:11], xp[13:11]);
        chk("R4 N field", pll_word[10:4], xp[10:4]);
        chk("R5 E bits", pll_word[16:14], xp[16:14]);
        chk("R6 dot bit", pll_word[17], xp[17]);
        chk("R11 whole pll_word", pll_word, xp);
        chk("R12 div_word", div_word, xd);
        chk("R7 error", err_hz, err);
        keep_pll = pll_word;
        @(negedge clk);
        chk("R13 done pulse length", done, 0);
        repeat (4) @(negedge clk);
        chk("R13 result held", pll_word, keep_pll);
    endtask

    initial begin
        int lat;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 no_solution", no_solution, 1);
        chk("R1 err", err_hz, 64'hFFFF_FFFF);
        chk("R1 words", {pll_word, div_word}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: nothing valid, then valid but just outside the window
        run(20_000_000, 20_000_000, 20_000_000, 3'b000, 50_000_000, 0, 0, lat);
        chk("R2 err all ones", err_hz, 64'hFFFF_FFFF);
        run(11_999_999, 192_000_001, 20_000_000, 3'b011, 50_000_000, 0, 0, lat);
        chk("R2 out-of-window refs", no_solution, 1);

        // R9: exact hit on the first candidate ends early
        run(20_000_000, 0, 0, 3'b001, 100_000_000, 1, 0, lat);
        chk("R9 exact error", err_hz, 0);
        chk("R9 early stop latency", (lat < 400), 1);
        chk("R9 N field n=60", pll_word[10:4], 59);
        chk("R7 R12 div=6", div_word, (1 << 17) | (1 << 16) | 5);

        // sweep targets on one reference, alternating the /7 stage (R6, R7)
        for (int k = 0; k < 5; k++)
            run(20_000_000, 0, 0, 3'b001, 25_000_000 + k * 13_333_337, k[0], 0, lat);

        // R8: identical references tie, the first is kept
        run(20_000_000, 20_000_000, 0, 3'b011, 33_000_000, 0, 0, lat);
        chk("R8 tie keeps source 0", src_sel, 0);

        // R2 boundaries accepted: 12 MHz on the crystal, 192 MHz on input 1
        run(0, 0, 12_000_000, 3'b100, 50_000_000, 1, 0, lat);
        chk("R2 12 MHz accepted", no_solution, 0);
        run(0, 192_000_000, 0, 3'b010, 74_250_000, 0, 0, lat);
        chk("R2 192 MHz accepted", no_solution, 0);

        // R10: result carried across three sources
        run(20_000_000, 27_000_000, 25_000_000, 3'b111, 74_250_000, 1, 0, lat);

        // R13: start during a search is ignored
        run(20_000_000, 0, 0, 3'b001, 41_000_000, 0, 1, lat);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule